// File: doc/BRIEF.md
# GHASH Field Multiplier

This block multiplies two elements of the binary field GF(2^128) used by the GHASH universal hash of Galois/Counter Mode. A caller presents a data block and a hash subkey, both in the byte-oriented GCM bit encoding, and pulses `start`. Three clock cycles later the fully reduced 128-bit product appears on `result` together with a one-cycle `done` pulse. The product stays on `result` until the next product is finished.

Inside, the operands are bit-reflected into natural polynomial order. One 64x64 carry-less multiplier is shared across three Karatsuba partial products: high halves, low halves, and the XOR of the halves. These are combined into a 255-bit product. That product is folded back into the field with shifts and XORs that follow the sparse reduction polynomial. The result is reflected back to the GCM encoding.

A GHASH engine built around this block supplies the running accumulator XORed with the next data block as `x_in`, and the subkey as `h_in`. Accumulation, length blocks and tag generation sit outside.

Top module: `ghash_gfmul`

## Requirements
- R1: Operands and result use the GCM reflected encoding. Port bit 127-i carries the coefficient of x^i, so the multiplicative identity is 128'h8000_0000_0000_0000_0000_0000_0000_0000.
- R2: `result` equals the product of `x_in` and `h_in` modulo x^128 + x^7 + x^2 + x + 1, fully reduced to 128 bits, for arbitrary operand values.
- R3: Multiplying any operand by the encoded identity, on either input, returns that operand unchanged.
- R4: Multiplying by zero, on either input, returns zero.
- R5: Suppose `start` is sampled high while the block is idle. Then `done` is high in the cycle that follows the third rising edge after that sampling edge, and it stays high for exactly one cycle.
- R6: `start` has no effect while a multiplication is in progress. The result of that multiplication is delivered unchanged, and no extra `done` pulse follows.
- R7: `result` changes only in the cycle in which `done` rises, and holds its value until the next completed multiplication.
- R8: While `rst_n` is low, and immediately after it is released, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; sampled only when idle |
| x_in | input | 128 | First operand, GCM encoding |
| h_in | input | 128 | Second operand (hash subkey), GCM encoding |
| result | output | 128 | Reduced product, GCM encoding |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Suppose a partial-product register or the step counter holds a wrong value. The error reaches `result` at the completing edge, exactly three cycles after the accepting edge, and it shows as a miscompare against a bit-serial field model. A step sequencer that skips or repeats a state moves the `done` pulse off its fixed latency at once. A busy flag that clears early lets a second `start` overwrite the operands, and this is visible as a wrong product on the first request. Reduction faults appear only for operands whose raw product has degree 128 or above. The vectors therefore include dense, high-order operands.

// File: rtl/ghash_pkg.sv
// Shared constants for the GHASH field multiplier.
// Assumes a 128-bit field split into two equal halves for Karatsuba.
package ghash_pkg;
    localparam int FIELD_W = 128;
    localparam int HALF_W  = FIELD_W / 2;
    localparam int PROD_W  = 2 * FIELD_W - 1;
    localparam int HPROD_W = 2 * HALF_W - 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gf_state_e;
endpackage

// File: rtl/ghash_bitrev.sv
// Reverses the bit order of a vector. Converts between the GCM reflected
// encoding and natural polynomial order (coefficient i at index i).
// Assumes nothing beyond a fixed width; pure wiring.
module ghash_bitrev #(
    parameter int W = 128
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/ghash_clmul.sv
// Combinational carry-less multiplier of two W-bit polynomials.
// Assumes natural bit order; produces a 2W-1 bit product.
module ghash_clmul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    localparam int PW = 2 * W - 1;

    // Accumulate shifted copies of a for each set bit of b.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) p = p ^ ({{(PW-W){1'b0}}, a} << i);
        end
    end
endmodule

// File: rtl/ghash_reduce.sv
// Folds a 2*FW-1 bit carry-less product into the field modulo
// x^FW + x^7 + x^2 + x + 1, using shifts and XORs only.
// Assumes FW is at least 16 so two folds fully reduce.
module ghash_reduce #(
    parameter int FW = 128
) (
    input  logic [2*FW-2:0] prod,
    output logic [FW-1:0]   rem
);
    localparam int PW   = 2 * FW - 1;
    localparam int TOPT = 7;            // highest tap below x^FW
    localparam int TW   = FW + TOPT - 1; // width after first fold
    localparam int OW   = TW - FW;      // overflow bits of first fold

    logic [FW-2:0] hi;
    logic [TW-1:0] hi_ext;
    logic [TW-1:0] fold1;
    logic [OW-1:0] ovf;
    logic [FW-1:0] ovf_ext;
    logic [FW-1:0] fold2;

    assign hi      = prod[PW-1:FW];
    assign hi_ext  = {{(TW-FW+1){1'b0}}, hi};
    assign ovf     = fold1[TW-1:FW];
    assign ovf_ext = {{(FW-OW){1'b0}}, ovf};

    // First fold: high part times (1 + x + x^2 + x^7).
    always_comb begin
        fold1 = hi_ext ^ (hi_ext << 1) ^ (hi_ext << 2) ^ (hi_ext << TOPT);
    end

    // Second fold: the few bits that spilled past degree FW-1.
    always_comb begin
        fold2 = ovf_ext ^ (ovf_ext << 1) ^ (ovf_ext << 2) ^ (ovf_ext << TOPT);
    end

    assign rem = prod[FW-1:0] ^ fold1[FW-1:0] ^ fold2;
endmodule

// File: rtl/ghash_gfmul.sv
// GHASH GF(2^128) multiplier. It accepts operands in GCM encoding on start
// while idle, runs three Karatsuba steps on one shared 64x64 carry-less
// multiplier, reduces, and registers the result with a one-cycle done.
// Assumes start is ignored while busy; the result holds between operations.
module ghash_gfmul
    import ghash_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FIELD_W-1:0]  x_in,
    input  logic [FIELD_W-1:0]  h_in,
    output logic [FIELD_W-1:0]  result,
    output logic                done
);
    localparam int STEPS  = 3;
    localparam int STEP_W = $clog2(STEPS);

    gf_state_e            state_q;
    logic [STEP_W-1:0]    step_q;
    logic [FIELD_W-1:0]   a_q, b_q;
    logic [HPROD_W-1:0]   p_hi_q, p_lo_q;
    logic [FIELD_W-1:0]   x_poly, h_poly;
    logic [HALF_W-1:0]    mul_a, mul_b;
    logic [HPROD_W-1:0]   mul_p;
    logic [HPROD_W-1:0]   mid;
    logic [PROD_W-1:0]    full;
    logic [FIELD_W-1:0]   red_poly, red_enc;
    logic                 busy;
    logic                 accept;
    logic                 last_step;

    assign busy      = (state_q == ST_RUN);
    assign accept    = start && !busy;
    assign last_step = busy && (step_q == STEP_W'(STEPS-1));

    ghash_bitrev #(.W(FIELD_W)) u_rev_x (.din(x_in),     .dout(x_poly));
    ghash_bitrev #(.W(FIELD_W)) u_rev_h (.din(h_in),     .dout(h_poly));
    ghash_bitrev #(.W(FIELD_W)) u_rev_r (.din(red_poly), .dout(red_enc));

    // Select the Karatsuba operand pair for the current step.
    always_comb begin
        unique case (step_q)
            STEP_W'(0): begin
                mul_a = a_q[FIELD_W-1:HALF_W];
                mul_b = b_q[FIELD_W-1:HALF_W];
            end
            STEP_W'(1): begin
                mul_a = a_q[HALF_W-1:0];
                mul_b = b_q[HALF_W-1:0];
            end
            default: begin
                mul_a = a_q[FIELD_W-1:HALF_W] ^ a_q[HALF_W-1:0];
                mul_b = b_q[FIELD_W-1:HALF_W] ^ b_q[HALF_W-1:0];
            end
        endcase
    end

    ghash_clmul #(.W(HALF_W)) u_clmul (.a(mul_a), .b(mul_b), .p(mul_p));

    // Recover the middle term and assemble the 255-bit product.
    always_comb begin
        mid  = mul_p ^ p_hi_q ^ p_lo_q;
        full = ({{(PROD_W-HPROD_W){1'b0}}, p_hi_q} << FIELD_W)
             ^ ({{(PROD_W-HPROD_W){1'b0}}, mid}    << HALF_W)
             ^  {{(PROD_W-HPROD_W){1'b0}}, p_lo_q};
    end

    ghash_reduce #(.FW(FIELD_W)) u_reduce (.prod(full), .rem(red_poly));

    // Sequencer: idle/run state and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else if (accept) begin
            state_q <= ST_RUN;
            step_q  <= '0;
        end else if (last_step) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else if (busy) begin
            step_q  <= step_q + 1'b1;
        end
    end

    // Operand capture in natural polynomial order on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= x_poly;
            b_q <= h_poly;
        end
    end

    // Store the outer Karatsuba products as their steps complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_hi_q <= '0;
            p_lo_q <= '0;
        end else if (busy && step_q == STEP_W'(0)) begin
            p_hi_q <= mul_p;
        end else if (busy && step_q == STEP_W'(1)) begin
            p_lo_q <= mul_p;
        end
    end

    // Register the reduced result and pulse done on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= last_step;
            if (last_step) result <= red_enc;
        end
    end
endmodule

// File: rtl/ghash_gfmul_chk.sv
// Protocol checker for ghash_gfmul, attached by bind.
// Assumes busy reflects the multiplier's internal run state.
module ghash_gfmul_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [127:0] result
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##4 done); // R5

    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !busy, 4)); // R6

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7
endmodule

bind ghash_gfmul ghash_gfmul_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/ghash_gfmul_bench.sv
// Self-checking bench for ghash_gfmul against a bit-serial field model.
module ghash_gfmul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [127:0] ONE = {8'h80, 120'h0};

    localparam logic [127:0] VX [NVEC] = '{
        128'h0388dace60b6a392f328c2b971b2fe78,
        128'hffffffffffffffffffffffffffffffff,
        128'h00000000000000000000000000000001,
        128'h0123456789abcdeffedcba9876543210,
        128'h40000000000000000000000000000000,
        128'hdeadbeefcafef00d0badc0de12345678,
        128'h80000000000000000000000000000001,
        128'haaaaaaaaaaaaaaaa5555555555555555
    };
    localparam logic [127:0] VH [NVEC] = '{
        128'h66e94bd4ef8a2c3b884cfa59ca342b2e,
        128'hffffffffffffffffffffffffffffffff,
        128'h00000000000000000000000000000001,
        128'hb83b533708bf535d0aa6e52980d53b78,
        128'h00000000000000000000000000000001,
        128'h1122334455667788990011223344aabb,
        128'hfedcba98765432100123456789abcdef,
        128'h5555555555555555aaaaaaaaaaaaaaaa
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] x_in = '0;
    logic [127:0] h_in = '0;
    logic [127:0] result;
    logic         done;
    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ghash_gfmul u_ghash_gfmul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .h_in(h_in), .result(result), .done(done)
    );

    // Bit-serial GCM multiply: bit 127 of the port is coefficient x^0.
    function automatic logic [127:0] ref_mul(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] z = '0;
        logic [127:0] v = y;
        for (int i = 0; i < 128; i++) begin
            if (x[127-i]) z = z ^ v;
            if (v[0]) v = (v >> 1) ^ {8'he1, 120'h0};
            else      v = v >> 1;
        end
        return z;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one multiplication, verify done timing and the product.
    task automatic run(input string req, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] exp);
        @(negedge clk);
        start = 1'b1; x_in = a; h_in = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk); #1;
        check("R5 done early", {127'b0, done}, 128'd0);
        @(posedge clk); #1;
        check("R5 done early", {127'b0, done}, 128'd0);
        @(posedge clk); #1;
        check("R5 done at latency", {127'b0, done}, 128'd1);
        check(req, result, exp);
        @(posedge clk); #1;
        check("R5 done single cycle", {127'b0, done}, 128'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset done", {127'b0, done}, 128'd0);
        check("R8 reset result", result, 128'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 after release done", {127'b0, done}, 128'd0);
        check("R8 after release result", result, 128'd0);

        // R2: vector table against the field model
        for (int k = 0; k < NVEC; k++) begin
            run("R2 product", VX[k], VH[k], ref_mul(VX[k], VH[k]));
        end
        // R1/R3: identity on both sides
        run("R1 identity encoding", ONE, ONE, ONE);
        run("R3 identity on h", VX[5], ONE, VX[5]);
        run("R3 identity on x", ONE, VH[3], VH[3]);
        // R4: zero on both sides
        run("R4 zero on h", VX[1], 128'd0, 128'd0);
        run("R4 zero on x", 128'd0, VH[0], 128'd0);

        // R6/R7: start while busy is ignored, result holds afterwards
        @(negedge clk);
        start = 1'b1; x_in = VX[3]; h_in = VH[3];
        @(posedge clk);
        @(negedge clk);
        x_in = VX[7]; h_in = VH[7];
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        #1;
        check("R6 no early done", {127'b0, done}, 128'd0);
        @(posedge clk); #1;
        check("R6 done on first request", {127'b0, done}, 128'd1);
        check("R6 first operands kept", result, ref_mul(VX[3], VH[3]));
        held = result;
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); #1;
            check("R6 no extra done", {127'b0, done}, 128'd0);
        end
        check("R7 result holds", result, held);
        @(negedge clk);
        x_in = VX[0]; h_in = VH[0];
        @(posedge clk); #1;
        check("R7 inputs alone do not change result", result, held);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule